// File: doc/BRIEF.md
# Index-Prefix Register Operand Decoder

This block sits in the decode stage of an 8-bit accumulator CPU. It takes the instruction byte stream one byte per accepted cycle. It remembers whether an index prefix is pending, and which of the two index registers it names. For register moves, 8-bit increment and decrement, load-immediate and accumulator ALU opcodes, it produces a 4-bit source select and a 4-bit destination select. When a prefix is pending, every register field that would name H or L is steered to the high or low half of the chosen index register instead.

When a prefixed opcode names the memory operand, the block leaves every field of that opcode unremapped and raises a displaced-memory request. It also consumes, without decoding, the displacement byte and any immediate data byte, so these are never mistaken for opcodes. A pending index prefix followed by the extended-opcode byte is reported as an illegal sequence. Results appear on registered outputs one cycle after the byte that completes them.

Top module: `idxpfx_decoder`

## Requirements
- R1: While reset is asserted, and after it is released, dec_valid, seq_illegal, dec_pfx_used and dec_mem are 0, and no prefix is pending. A prefix byte received before a reset has no effect on the first opcode after that reset.
- R2: Without a prefix, an accepted opcode is reported with dec_valid one cycle later. dec_kind uses these codes: 0 other, 1 move, 2 increment, 3 decrement, 4 load-immediate, 5 ALU. A move (0x40–0x7F except 0x76) has destination = bits 5:3 and source = bits 2:0. Register codes are 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory, 7 A. An unused select reads 15. Opcodes of kind 0, such as 0x76, report 15 in both selects.
- R3: After prefix 0xDD, a move field naming H reads 8 and one naming L reads 9. After 0xFD, H reads 10 and L reads 11. When both fields name H or L, both are remapped: 0xDD 0x65 gives source 9 and destination 8.
- R4: Increment (00rrr100) and decrement (00rrr101) report the field rrr as both source and destination. Load-immediate (00rrr110) reports it as destination with source 15. All three forms are remapped under a prefix.
- R5: ALU opcodes (10ooorrr) report source rrr and destination 7 (A). Under a prefix, rrr is remapped, and destination A is never remapped.
- R6: If a prefixed opcode has a field equal to 6, dec_mem is 1 and no field of that opcode is remapped. Without a prefix, dec_mem is 0 even when a field is 6.
- R7: Bytes following an opcode are consumed without being decoded or treated as prefixes. Load-immediate is followed by one data byte, and a prefixed opcode with a memory field is followed by one displacement byte. A prefixed memory load-immediate (0x36) is therefore followed by two skipped bytes.
- R8: A pending prefix is consumed by the next decoded opcode of any kind, and it is kept across idle cycles until then. dec_pfx_used is 1 exactly on results of opcodes that consumed a prefix.
- R9: An index prefix arriving while another is pending replaces it. No result is produced for the discarded prefix.
- R10: Byte 0xED while an index prefix is pending pulses seq_illegal one cycle later, with dec_valid 0. The prefix is then cleared. Without a pending prefix, 0xED decodes as kind 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | in_byte is accepted this cycle |
| in_byte | input | 8 | Instruction stream byte |
| dec_valid | output | 1 | A decoded opcode result is present |
| dec_kind | output | 3 | Opcode kind code |
| dec_src | output | 4 | Source register select |
| dec_dst | output | 4 | Destination register select |
| dec_mem | output | 1 | Displaced-memory request for the execution stage |
| dec_pfx_used | output | 1 | This opcode consumed an index prefix |
| seq_illegal | output | 1 | Illegal prefix sequence detected |

## Verification
Every result, whether a decode or an illegal-sequence pulse, is due exactly one clock after the edge that accepts the completing byte. Prefix bytes and skipped bytes produce nothing at all. The driver queues an expected item only for bytes that complete a result, and it drives inputs on the falling edge. The monitor looks at the outputs on each falling edge and pops one item whenever either strobe is high. Any strobe with no queued item, and any item still queued after the stream drains, counts as a failure. A missing, extra or late result therefore shows up as a mismatch.

// File: rtl/idxdec_pkg.sv
package idxdec_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 4;
  localparam int FLD_W  = 3;

  typedef enum logic [1:0] {
    PFX_NONE = 2'd0,
    PFX_X    = 2'd1,
    PFX_Y    = 2'd2
  } pfx_e;

  typedef logic [2:0] kind_t;
  localparam kind_t KIND_OTHER = 3'd0;
  localparam kind_t KIND_MOVE  = 3'd1;
  localparam kind_t KIND_INC   = 3'd2;
  localparam kind_t KIND_DEC   = 3'd3;
  localparam kind_t KIND_LDI   = 3'd4;
  localparam kind_t KIND_ALU   = 3'd5;

  localparam logic [FLD_W-1:0] FLD_H   = 3'd4;
  localparam logic [FLD_W-1:0] FLD_L   = 3'd5;
  localparam logic [FLD_W-1:0] FLD_MEM = 3'd6;
  localparam logic [FLD_W-1:0] FLD_A   = 3'd7;

  localparam logic [SEL_W-1:0] SEL_XH   = 4'd8;
  localparam logic [SEL_W-1:0] SEL_XL   = 4'd9;
  localparam logic [SEL_W-1:0] SEL_YH   = 4'd10;
  localparam logic [SEL_W-1:0] SEL_YL   = 4'd11;
  localparam logic [SEL_W-1:0] SEL_NONE = 4'd15;
endpackage

// File: rtl/idxdec_classify.sv
module idxdec_classify
  import idxdec_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  output kind_t             kind,
  output logic [FLD_W-1:0]  fld_src,
  output logic [FLD_W-1:0]  fld_dst,
  output logic              use_src,
  output logic              use_dst,
  output logic              has_mem,
  output logic              imm_byte
);
  localparam logic [BYTE_W-1:0] OP_HALT = 8'h76;

  always_comb begin
    kind     = KIND_OTHER;
    fld_src  = '0;
    fld_dst  = '0;
    use_src  = 1'b0;
    use_dst  = 1'b0;
    imm_byte = 1'b0;
    case (op[7:6])
      2'b00: begin
        case (op[2:0])
          3'b100: begin
            kind    = KIND_INC;
            fld_src = op[5:3];
            fld_dst = op[5:3];
            use_src = 1'b1;
            use_dst = 1'b1;
          end
          3'b101: begin
            kind    = KIND_DEC;
            fld_src = op[5:3];
            fld_dst = op[5:3];
            use_src = 1'b1;
            use_dst = 1'b1;
          end
          3'b110: begin
            kind     = KIND_LDI;
            fld_dst  = op[5:3];
            use_dst  = 1'b1;
            imm_byte = 1'b1;
          end
          default: ;
        endcase
      end
      2'b01: begin
        if (op != OP_HALT) begin
          kind    = KIND_MOVE;
          fld_src = op[2:0];
          fld_dst = op[5:3];
          use_src = 1'b1;
          use_dst = 1'b1;
        end
      end
      2'b10: begin
        kind    = KIND_ALU;
        fld_src = op[2:0];
        fld_dst = FLD_A;
        use_src = 1'b1;
        use_dst = 1'b1;
      end
      default: ;
    endcase
  end

  assign has_mem = (use_src && (fld_src == FLD_MEM)) ||
                   (use_dst && (fld_dst == FLD_MEM));
endmodule

// File: rtl/idxdec_remap.sv
module idxdec_remap
  import idxdec_pkg::*;
(
  input  logic [FLD_W-1:0] code,
  input  logic             use_fld,
  input  logic             idx_on,
  input  pfx_e             pfx,
  output logic [SEL_W-1:0] sel
);
  always_comb begin
    if (!use_fld) begin
      sel = SEL_NONE;
    end else if (idx_on && (code == FLD_H)) begin
      sel = (pfx == PFX_Y) ? SEL_YH : SEL_XH;
    end else if (idx_on && (code == FLD_L)) begin
      sel = (pfx == PFX_Y) ? SEL_YL : SEL_XL;
    end else begin
      sel = SEL_W'(code);
    end
  end
endmodule

// File: rtl/idxdec_track.sv
module idxdec_track
  import idxdec_pkg::*;
#(
  parameter logic [BYTE_W-1:0] PFX_X_BYTE = 8'hDD,
  parameter logic [BYTE_W-1:0] PFX_Y_BYTE = 8'hFD,
  parameter logic [BYTE_W-1:0] EXT_BYTE   = 8'hED,
  parameter int                SKIP_MAX   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              imm_byte,
  input  logic              has_mem,
  output pfx_e              pfx,
  output logic              take_op,
  output logic              illegal_hit
);
  localparam int SKIP_W = $clog2(SKIP_MAX + 1);

  pfx_e              pfx_q, pfx_d;
  logic [SKIP_W-1:0] skip_q, skip_d;
  logic              pfx_on;

  assign pfx_on = (pfx_q != PFX_NONE);

  always_comb begin
    pfx_d       = pfx_q;
    skip_d      = skip_q;
    take_op     = 1'b0;
    illegal_hit = 1'b0;
    if (in_valid) begin
      if (skip_q != '0) begin
        skip_d = skip_q - 1'b1;
      end else if (in_byte == PFX_X_BYTE) begin
        pfx_d = PFX_X;
      end else if (in_byte == PFX_Y_BYTE) begin
        pfx_d = PFX_Y;
      end else if ((in_byte == EXT_BYTE) && pfx_on) begin
        illegal_hit = 1'b1;
        pfx_d       = PFX_NONE;
      end else begin
        take_op = 1'b1;
        pfx_d   = PFX_NONE;
        skip_d  = SKIP_W'(imm_byte) + SKIP_W'(has_mem && pfx_on);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfx_q  <= PFX_NONE;
      skip_q <= '0;
    end else begin
      pfx_q  <= pfx_d;
      skip_q <= skip_d;
    end
  end

  assign pfx = pfx_q;

  p_skip_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    skip_q <= SKIP_W'(SKIP_MAX));

  p_prefix_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_op |=> (pfx_q == PFX_NONE));

  p_illegal_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_hit |=> (pfx_q == PFX_NONE) && (skip_q == '0));
endmodule

// File: rtl/idxpfx_decoder.sv
module idxpfx_decoder
  import idxdec_pkg::*;
#(
  parameter logic [BYTE_W-1:0] PFX_X_BYTE = 8'hDD,
  parameter logic [BYTE_W-1:0] PFX_Y_BYTE = 8'hFD,
  parameter logic [BYTE_W-1:0] EXT_BYTE   = 8'hED,
  parameter int                RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              dec_valid,
  output logic [2:0]        dec_kind,
  output logic [SEL_W-1:0]  dec_src,
  output logic [SEL_W-1:0]  dec_dst,
  output logic              dec_mem,
  output logic              dec_pfx_used,
  output logic              seq_illegal
);
  localparam int N_FLD = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[RST_STAGES-1];

  kind_t            kind;
  logic [FLD_W-1:0] fld_src, fld_dst;
  logic             use_src, use_dst, has_mem, imm_byte;

  idxdec_classify u_class (
    .op       (in_byte),
    .kind     (kind),
    .fld_src  (fld_src),
    .fld_dst  (fld_dst),
    .use_src  (use_src),
    .use_dst  (use_dst),
    .has_mem  (has_mem),
    .imm_byte (imm_byte)
  );

  pfx_e pfx;
  logic take_op, illegal_hit;

  idxdec_track #(
    .PFX_X_BYTE (PFX_X_BYTE),
    .PFX_Y_BYTE (PFX_Y_BYTE),
    .EXT_BYTE   (EXT_BYTE),
    .SKIP_MAX   (2)
  ) u_track (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .in_valid    (in_valid),
    .in_byte     (in_byte),
    .imm_byte    (imm_byte),
    .has_mem     (has_mem),
    .pfx         (pfx),
    .take_op     (take_op),
    .illegal_hit (illegal_hit)
  );

  logic             pfx_on, idx_on;
  logic [FLD_W-1:0] fld_a [N_FLD];
  logic             use_a [N_FLD];
  logic [SEL_W-1:0] sel_a [N_FLD];

  assign pfx_on   = (pfx != PFX_NONE);
  assign idx_on   = pfx_on && !has_mem;
  assign fld_a[0] = fld_src;
  assign fld_a[1] = fld_dst;
  assign use_a[0] = use_src;
  assign use_a[1] = use_dst;

  for (genvar g = 0; g < N_FLD; g++) begin : g_remap
    idxdec_remap u_remap (
      .code    (fld_a[g]),
      .use_fld (use_a[g]),
      .idx_on  (idx_on),
      .pfx     (pfx),
      .sel     (sel_a[g])
    );
  end

  logic             valid_q, illegal_q, mem_q, used_q;
  logic             valid_d, illegal_d, mem_d, used_d;
  kind_t            kind_q;
  logic [SEL_W-1:0] src_q, dst_q;

  always_comb begin
    valid_d   = take_op;
    illegal_d = illegal_hit;
    used_d    = take_op && pfx_on;
    mem_d     = take_op && pfx_on && has_mem;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
      used_q    <= 1'b0;
      mem_q     <= 1'b0;
      kind_q    <= KIND_OTHER;
      src_q     <= SEL_NONE;
      dst_q     <= SEL_NONE;
    end else begin
      valid_q   <= valid_d;
      illegal_q <= illegal_d;
      used_q    <= used_d;
      mem_q     <= mem_d;
      if (take_op) begin
        kind_q <= kind;
        src_q  <= sel_a[0];
        dst_q  <= sel_a[1];
      end
    end
  end

  assign dec_valid    = valid_q;
  assign seq_illegal  = illegal_q;
  assign dec_pfx_used = used_q;
  assign dec_mem      = mem_q;
  assign dec_kind     = kind_q;
  assign dec_src      = src_q;
  assign dec_dst      = dst_q;

  p_quiet_without_byte_r1: assert property (@(posedge clk) disable iff (!rst_n_int)
    !in_valid |=> !dec_valid && !seq_illegal);

  p_illegal_alone_r10: assert property (@(posedge clk) disable iff (!rst_n_int)
    seq_illegal |-> !dec_valid && !dec_pfx_used);

  p_used_with_result_r8: assert property (@(posedge clk) disable iff (!rst_n_int)
    dec_pfx_used |-> dec_valid);

  p_mem_needs_prefix_r6: assert property (@(posedge clk) disable iff (!rst_n_int)
    dec_mem |-> dec_valid && dec_pfx_used);

  p_index_needs_prefix_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (dec_valid && ((dec_src[3:2] == 2'b10) || (dec_dst[3:2] == 2'b10)))
      |-> dec_pfx_used && !dec_mem);

  p_one_index_reg_r9: assert property (@(posedge clk) disable iff (!rst_n_int)
    (dec_valid && (dec_src[3:2] == 2'b10) && (dec_dst[3:2] == 2'b10))
      |-> (dec_src[1] == dec_dst[1]));

  p_alu_dest_a_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (dec_valid && (dec_kind == KIND_ALU)) |-> (dec_dst == 4'd7));
endmodule

// File: tb/idxpfx_decoder_tb_top.sv
module idxpfx_decoder_tb_top;
  localparam int CLK_PERIOD   = 10;
  localparam int WATCHDOG_CYC = 20000;

  localparam logic [2:0] K_OTH = 3'd0, K_MOV = 3'd1, K_INC = 3'd2,
                         K_DEC = 3'd3, K_LDI = 3'd4, K_ALU = 3'd5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       dec_valid, dec_mem, dec_pfx_used, seq_illegal;
  logic [2:0] dec_kind;
  logic [3:0] dec_src, dec_dst;

  always #(CLK_PERIOD/2) clk = ~clk;

  idxpfx_decoder dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_byte      (in_byte),
    .dec_valid    (dec_valid),
    .dec_kind     (dec_kind),
    .dec_src      (dec_src),
    .dec_dst      (dec_dst),
    .dec_mem      (dec_mem),
    .dec_pfx_used (dec_pfx_used),
    .seq_illegal  (seq_illegal)
  );

  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  logic [13:0] exp_q[$];
  string       tag_q[$];

  function automatic void check(input string tag, input logic [13:0] act,
                                input logic [13:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endfunction

  task automatic exp_dec(input logic [2:0] k, input logic [3:0] s,
                         input logic [3:0] d, input logic m, input logic u,
                         input string tag);
    exp_q.push_back({1'b0, k, s, d, m, u});
    tag_q.push_back(tag);
  endtask

  task automatic exp_ill(input string tag);
    exp_q.push_back({1'b1, 13'b0});
    tag_q.push_back(tag);
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_byte  = 8'h00;
    end
  endtask

  task automatic check_quiet(input string tag);
    check(tag, {10'b0, dec_valid, seq_illegal, dec_pfx_used, dec_mem}, 14'b0);
  endtask

  // Monitor: one queued item per strobe, sampled on the falling edge.
  always @(negedge clk) begin
    if (rst_n && ((dec_valid === 1'b1) || (seq_illegal === 1'b1))) begin
      logic [13:0] act;
      act = (seq_illegal === 1'b1) ? {1'b1, 13'b0}
          : {1'b0, dec_kind, dec_src, dec_dst, dec_mem, dec_pfx_used};
      if (exp_q.size() == 0) begin
        n_run++;
        n_fail++;
        $display("FAIL R1 unexpected result act=%h exp=none", act);
      end else begin
        check(tag_q.pop_front(), act, exp_q.pop_front());
      end
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R1 watchdog expired act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    check_quiet("R1 in reset");
    @(negedge clk) rst_n = 1'b1;
    idle(3);
    check_quiet("R1 after release");

    // R1: nothing pending out of reset
    exp_dec(K_MOV, 4'd5, 4'd4, 0, 0, "R1 no prefix after reset"); put(8'h65);

    // R2: plain decode
    exp_dec(K_MOV, 4'd1, 4'd0, 0, 0, "R2 move B<-C");   put(8'h41);
    exp_dec(K_OTH, 4'd15, 4'd15, 0, 0, "R2 halt other"); put(8'h76);
    idle(2);
    exp_dec(K_MOV, 4'd6, 4'd7, 0, 0, "R6 unprefixed mem no request"); put(8'h7E);

    // R3: move remap
    put(8'hDD); exp_dec(K_MOV, 4'd8, 4'd0, 0, 1, "R3 B<-XH");   put(8'h44);
    put(8'hFD); exp_dec(K_MOV, 4'd11, 4'd7, 0, 1, "R3 A<-YL");  put(8'h7D);
    put(8'hDD); exp_dec(K_MOV, 4'd9, 4'd8, 0, 1, "R3 XH<-XL");  put(8'h65);
    put(8'hFD); exp_dec(K_MOV, 4'd10, 4'd10, 0, 1, "R3 YH<-YH"); put(8'h64);
    put(8'hDD); exp_dec(K_MOV, 4'd7, 4'd9, 0, 1, "R3 XL<-A");   put(8'h6F);
    put(8'hFD); exp_dec(K_MOV, 4'd2, 4'd10, 0, 1, "R3 YH<-D");  put(8'h62);

    // R4: inc / dec / load-immediate
    put(8'hDD); exp_dec(K_INC, 4'd8, 4'd8, 0, 1, "R4 inc XH");   put(8'h24);
    put(8'hFD); exp_dec(K_DEC, 4'd11, 4'd11, 0, 1, "R4 dec YL"); put(8'h2D);
    put(8'hDD); exp_dec(K_LDI, 4'd15, 4'd8, 0, 1, "R4 ldi XH");  put(8'h26);
    put(8'hDD);
    exp_dec(K_MOV, 4'd5, 4'd4, 0, 0, "R7 data byte not a prefix"); put(8'h65);

    // R5: ALU
    put(8'hFD); exp_dec(K_ALU, 4'd10, 4'd7, 0, 1, "R5 sub YH"); put(8'h94);
    put(8'hDD); exp_dec(K_ALU, 4'd9, 4'd7, 0, 1, "R5 cp XL");   put(8'hBD);
    exp_dec(K_ALU, 4'd4, 4'd7, 0, 0, "R5 add H plain");         put(8'h84);
    put(8'hFD); exp_dec(K_ALU, 4'd7, 4'd7, 0, 1, "R5 adc A keeps A"); put(8'h8F);

    // R6: memory field under prefix
    put(8'hDD); exp_dec(K_MOV, 4'd6, 4'd4, 1, 1, "R6 H<-mem no remap"); put(8'h66);
    put(8'hFD);
    exp_dec(K_MOV, 4'd4, 4'd7, 0, 0, "R7 disp skipped"); put(8'h7C);
    put(8'hFD); exp_dec(K_MOV, 4'd4, 4'd6, 1, 1, "R6 mem<-H no remap"); put(8'h74);
    put(8'hED);
    exp_dec(K_INC, 4'd5, 4'd5, 0, 0, "R7 disp ED skipped"); put(8'h2C);
    put(8'hDD); exp_dec(K_ALU, 4'd6, 4'd7, 1, 1, "R6 add mem"); put(8'h86);
    put(8'h24);
    exp_dec(K_MOV, 4'd5, 4'd0, 0, 0, "R7 after alu disp"); put(8'h45);

    // R7: skip counts
    put(8'hDD); exp_dec(K_LDI, 4'd15, 4'd6, 1, 1, "R7 ldi mem prefixed"); put(8'h36);
    put(8'hDD); put(8'hED);
    exp_dec(K_MOV, 4'd4, 4'd0, 0, 0, "R7 two bytes skipped"); put(8'h44);
    exp_dec(K_LDI, 4'd15, 4'd0, 0, 0, "R7 ldi B"); put(8'h06);
    put(8'h41);
    exp_dec(K_INC, 4'd0, 4'd0, 0, 0, "R7 inc B after data"); put(8'h04);
    exp_dec(K_LDI, 4'd15, 4'd6, 0, 0, "R7 ldi mem plain"); put(8'h36);
    put(8'hDD);
    exp_dec(K_MOV, 4'd5, 4'd3, 0, 0, "R7 one byte only"); put(8'h5D);

    // R8: prefix consumed by any opcode, held across idle
    put(8'hDD); exp_dec(K_OTH, 4'd15, 4'd15, 0, 1, "R8 nop consumes"); put(8'h00);
    exp_dec(K_MOV, 4'd4, 4'd5, 0, 0, "R8 prefix gone"); put(8'h6C);
    put(8'hDD); idle(3);
    exp_dec(K_INC, 4'd9, 4'd9, 0, 1, "R8 held over idle"); put(8'h2C);

    // R9: replacement
    put(8'hDD); put(8'hFD);
    exp_dec(K_MOV, 4'd10, 4'd11, 0, 1, "R9 FD replaces DD"); put(8'h6C);
    put(8'hFD); put(8'hDD);
    exp_dec(K_LDI, 4'd15, 4'd9, 0, 1, "R9 DD replaces FD"); put(8'h2E);
    put(8'h55);
    exp_dec(K_MOV, 4'd5, 4'd7, 0, 0, "R9 single use"); put(8'h7D);

    // R10: illegal sequence
    put(8'hDD); exp_ill("R10 DD ED"); put(8'hED);
    exp_dec(K_MOV, 4'd4, 4'd0, 0, 0, "R10 prefix cleared"); put(8'h44);
    put(8'hFD); exp_ill("R10 FD ED"); put(8'hED);
    idle(1);
    exp_dec(K_MOV, 4'd5, 4'd4, 0, 0, "R10 cleared after idle"); put(8'h65);
    exp_dec(K_OTH, 4'd15, 4'd15, 0, 0, "R10 ED alone"); put(8'hED);
    exp_dec(K_MOV, 4'd4, 4'd0, 0, 0, "R10 after lone ED"); put(8'h44);
    put(8'hDD); put(8'hFD); exp_ill("R10 DD FD ED"); put(8'hED);
    idle(2);

    // R1: reset discards a pending prefix
    put(8'hDD); idle(1);
    rst_n = 1'b0;
    idle(2);
    check_quiet("R1 mid reset");
    @(negedge clk) rst_n = 1'b1;
    idle(3);
    exp_dec(K_MOV, 4'd5, 4'd4, 0, 0, "R1 prefix lost in reset"); put(8'h65);
    idle(4);

    n_run++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2 results missing act=%0d left exp=0", exp_q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule